// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A 32-line general-purpose I/O port reached through a single-cycle 32-bit register bus. Software sets which lines drive their pads and which lines sample them. It can gate each input buffer on its own, and it picks, per line, whether a falling edge alone or any edge raises an event. Pad inputs pass through a two-flop synchroniser. Edges are found on the synchronised value and latched into a write-one-to-clear event register. A mask register selects which latched events reach the single combined interrupt line.

Register bits use a reversed numbering: line n lives in bit 31-n of every register. The pad buses (`pad_in`, `pad_oe`, `pad_out`) are indexed by line number, so line n is at index n there. Registers are addressed by byte offset. Only word-aligned accesses take effect.

Top module: `gpio32_edge_irq`

## Requirements
- R1: Line n corresponds to register bit 31-n in every register, and to index n of `pad_in`, `pad_oe` and `pad_out`.
- R2: After reset every register reads 0, `pad_oe` and `pad_out` are all 0 and `irq` is 0.
- R3: A direction bit of 1 makes the line an output: `pad_oe` is 1 for it and `pad_out` carries its stored data bit. A line whose direction bit is 0 drives `pad_oe` 0 and `pad_out` 0, although its data bit is still stored.
- R4: A read of the data register (offset 0x08) returns, per bit, the stored value for output lines. For input lines it returns the synchronised pad value when the input-enable bit (offset 0x1C) is 1, and 0 otherwise.
- R5: A pad change made between clock edges appears in data reads after the second following rising edge, and not after the first.
- R6: Edge control (offset 0x14) bit 1 means only a falling synchronised edge sets the event bit, and bit 0 means either edge does. The event bit (offset 0x0C) reads 1 after the third rising edge that follows the pad change.
- R7: Writing the event register clears exactly the bits written as 1. Writing 0 leaves it unchanged, and only a detected edge sets a bit.
- R8: When an edge is detected in the same cycle that software clears that line's event bit, the bit remains set.
- R9: `irq` is 1 exactly when some bit is set in both the event register and the mask register (offset 0x10, 1 = enabled). A mask of 0 holds `irq` at 0.
- R10: Direction is at 0x00, and offsets 0x04 and 0x18 are reserved: they read 0 and ignore writes. An access whose address has bits [1:0] nonzero changes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input levels, index = line |
| pad_oe | output | 32 | Pad output enables, index = line |
| pad_out | output | 32 | Pad output values, index = line |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench builds the block with its default of 32 lines and two synchroniser stages. At that width the reversed bit order covers the whole word, and any off-by-one in the mirroring shows up at both ends, on line 0 and on line 31. Keeping two stages makes the event-latency window three edges long. This is short enough that the bench can line up a clearing write exactly on the detection edge and exercise the set-wins collision directly.

// File: rtl/gpio32_pkg.sv
package gpio32_pkg;

  localparam int BUS_W    = 32;
  localparam int BYTE_AW  = 5;
  localparam int WORD_LSB = 2;
  localparam int SEL_W    = BYTE_AW - WORD_LSB;

  // Word index of each register; byte offset = index * 4.
  typedef enum logic [SEL_W-1:0] {
    SEL_DIR   = 3'd0,  // 0x00
    SEL_ODRSV = 3'd1,  // 0x04 reserved
    SEL_DATA  = 3'd2,  // 0x08
    SEL_EVT   = 3'd3,  // 0x0C
    SEL_MASK  = 3'd4,  // 0x10
    SEL_EDGE  = 3'd5,  // 0x14
    SEL_RSV18 = 3'd6,  // 0x18 reserved
    SEL_IBE   = 3'd7   // 0x1C
  } reg_sel_e;

  function automatic reg_sel_e addr_to_sel(input logic [BYTE_AW-1:0] a);
    return reg_sel_e'(a[BYTE_AW-1:WORD_LSB]);
  endfunction

  function automatic logic addr_aligned(input logic [BYTE_AW-1:0] a);
    return a[WORD_LSB-1:0] == '0;
  endfunction

endpackage

// File: rtl/gpio32_sync.sv
module gpio32_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          if (s == 0) stage_q[s] <= d;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio32_edge_evt.sv
module gpio32_edge_evt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,      // synchronised inputs, register bit order
  input  logic [W-1:0] fall_only,  // 1: falling edge only, 0: both edges
  input  logic [W-1:0] clr,        // write-one-to-clear request
  output logic [W-1:0] evt_q,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] fall_vec
);

  logic [W-1:0] prev_q;
  logic [W-1:0] rise_vec;

  assign fall_vec = prev_q & ~level;
  assign rise_vec = ~prev_q & level;
  assign edge_hit = fall_vec | (rise_vec & ~fall_only);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= level;
      // A fresh edge outranks a simultaneous clear.
      evt_q  <= (evt_q & ~clr) | edge_hit;
    end
  end

endmodule

// File: rtl/gpio32_edge_irq.sv
module gpio32_edge_irq
  import gpio32_pkg::*;
#(
  parameter int N_LINES     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTE_AW-1:0] bus_addr,
  input  logic               bus_we,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  input  logic [N_LINES-1:0] pad_in,
  output logic [N_LINES-1:0] pad_oe,
  output logic [N_LINES-1:0] pad_out,
  output logic               irq
);

  // Line n <-> register bit N_LINES-1-n.
  function automatic logic [N_LINES-1:0] mirror(input logic [N_LINES-1:0] v);
    logic [N_LINES-1:0] r;
    for (int i = 0; i < N_LINES; i++) r[i] = v[N_LINES-1-i];
    return r;
  endfunction

  reg_sel_e sel;
  logic     aligned;
  logic     wr_ok;

  logic [N_LINES-1:0] dir_q, dout_q, mask_q, edge_ctrl_q, ibe_q;
  logic [N_LINES-1:0] pad_bits, sync_bits;
  logic [N_LINES-1:0] evt_clr, evt_q, edge_hit, fall_vec;
  logic [N_LINES-1:0] data_view;

  assign sel     = addr_to_sel(bus_addr);
  assign aligned = addr_aligned(bus_addr);
  assign wr_ok   = bus_we && aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q       <= '0;
      dout_q      <= '0;
      mask_q      <= '0;
      edge_ctrl_q <= '0;
      ibe_q       <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_DIR:  dir_q       <= bus_wdata;
        SEL_DATA: dout_q      <= bus_wdata;
        SEL_MASK: mask_q      <= bus_wdata;
        SEL_EDGE: edge_ctrl_q <= bus_wdata;
        SEL_IBE:  ibe_q       <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign pad_bits = mirror(pad_in);

  gpio32_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_bits),
    .q     (sync_bits)
  );

  assign evt_clr = (wr_ok && sel == SEL_EVT) ? bus_wdata : '0;

  gpio32_edge_evt #(.W(N_LINES)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (sync_bits),
    .fall_only (edge_ctrl_q),
    .clr       (evt_clr),
    .evt_q     (evt_q),
    .edge_hit  (edge_hit),
    .fall_vec  (fall_vec)
  );

  assign data_view = (dir_q & dout_q) | (~dir_q & ibe_q & sync_bits);

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (sel)
        SEL_DIR:  bus_rdata = dir_q;
        SEL_DATA: bus_rdata = data_view;
        SEL_EVT:  bus_rdata = evt_q;
        SEL_MASK: bus_rdata = mask_q;
        SEL_EDGE: bus_rdata = edge_ctrl_q;
        SEL_IBE:  bus_rdata = ibe_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pad_oe  = mirror(dir_q);
  assign pad_out = mirror(dir_q & dout_q);
  assign irq     = |(evt_q & mask_q);

endmodule

// File: rtl/gpio32_edge_irq_chk.sv
module gpio32_edge_irq_chk #(
  parameter int N_LINES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [4:0]         bus_addr,
  input logic               bus_we,
  input logic [N_LINES-1:0] bus_wdata,
  input logic [N_LINES-1:0] bus_rdata,
  input logic [N_LINES-1:0] pad_oe,
  input logic               irq,
  input logic [N_LINES-1:0] evt_q,
  input logic [N_LINES-1:0] edge_hit,
  input logic [N_LINES-1:0] fall_vec,
  input logic [N_LINES-1:0] edge_ctrl_q
);

  function automatic logic [N_LINES-1:0] flip(input logic [N_LINES-1:0] v);
    logic [N_LINES-1:0] r;
    for (int i = 0; i < N_LINES; i++) r[i] = v[N_LINES-1-i];
    return r;
  endfunction

  // R3 / R1: a direction write shows up mirrored on pad_oe next cycle.
  p_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h00) |=> (pad_oe == flip($past(bus_wdata))));

  // R9: clearing the mask silences the interrupt.
  p_mask_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h10 && bus_wdata == '0) |=> !irq);

  // R7: an event bit only rises where an edge was detected.
  p_new_evt_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~$past(evt_q) & ~$past(edge_hit)) == '0));

  // R8: a detected edge is always latched, even against a clear.
  p_hit_sets_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & $past(edge_hit)) == $past(edge_hit)));

  // R6: lines set to falling-only report nothing but falling edges.
  p_fall_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & edge_ctrl_q & ~fall_vec) == '0));

  // R10: reserved offsets read back zero.
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 5'h04 || bus_addr == 5'h18) |-> (bus_rdata == '0));

endmodule

bind gpio32_edge_irq gpio32_edge_irq_chk #(.N_LINES(N_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pad_oe      (pad_oe),
  .irq         (irq),
  .evt_q       (evt_q),
  .edge_hit    (edge_hit),
  .fall_vec    (fall_vec),
  .edge_ctrl_q (edge_ctrl_q)
);

// File: tb/gpio32_edge_irq_tb.sv
module gpio32_edge_irq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio32_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
  );

  // Bench-side restatement of the line/bit mirroring.
  function automatic logic [31:0] brev(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) if (v[i]) r[31-i] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] dir;
    logic [31:0] ibe;
    logic [31:0] dout;
    logic [31:0] pad;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 32'h8000_0000},
    '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0000_00FF, 32'hFFFF_FFFF, 32'h0000_FFFF},
    '{32'h0000_FFFF, 32'hFF00_0000, 32'h1234_5678, 32'h0000_00F0, 32'h0F00_5678},
    '{32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hAAAA_AAAA}
  };

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state of all registers and outputs.
    for (int k = 0; k < 8; k++) begin
      rd(5'(k * 4), v);
      check($sformatf("R2 reset reg 0x%0h", k * 4), v, 32'h0);
    end
    check("R2 reset pad_oe", pad_oe, 32'h0);
    check("R2 reset pad_out", pad_out, 32'h0);
    check("R2 reset irq", {31'h0, irq}, 32'h0);

    // R1 R3 R4: table of direction / input-enable / data patterns.
    for (int i = 0; i < 5; i++) begin
      wr(5'h00, VECS[i].dir);
      wr(5'h1C, VECS[i].ibe);
      wr(5'h08, VECS[i].dout);
      pad_in = VECS[i].pad;
      settle();
      rd(5'h08, v);
      check($sformatf("R4 R1 data read vec%0d", i), v, VECS[i].exp);
      check($sformatf("R3 pad_oe vec%0d", i), pad_oe, brev(VECS[i].dir));
      check($sformatf("R3 pad_out vec%0d", i), pad_out, brev(VECS[i].dir & VECS[i].dout));
    end

    // Quiet state for event tests.
    wr(5'h00, 32'h0);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0);
    pad_in = '0;
    settle();
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v);
    check("R7 clear all events", v, 32'h0);

    // R5 R6: latency of the data view and the event bit (line 8 -> bit 23).
    @(negedge clk);
    bus_addr = 5'h08;
    pad_in[8] = 1'b1;
    @(posedge clk); #1;
    check("R5 data after 1 edge", bus_rdata & 32'h0080_0000, 32'h0);
    @(posedge clk); #1;
    check("R5 data after 2 edges", bus_rdata & 32'h0080_0000, 32'h0080_0000);
    bus_addr = 5'h0C;
    #1 check("R6 no event after 2 edges", bus_rdata, 32'h0);
    @(posedge clk); #1;
    check("R6 event after 3 edges", bus_rdata, 32'h0080_0000);
    pad_in[8] = 1'b0;
    settle();
    wr(5'h0C, 32'hFFFF_FFFF);

    // R6: falling-only lines ignore rising edges (line 3 -> bit 28).
    wr(5'h14, 32'hFFFF_FFFF);
    pad_in[3] = 1'b1;
    settle();
    rd(5'h0C, v);
    check("R6 falling-only ignores rise", v, 32'h0);
    pad_in[3] = 1'b0;
    settle();
    rd(5'h0C, v);
    check("R6 falling-only catches fall", v, 32'h1000_0000);

    // R6 R1: both edges when control is 0 (line 31 -> bit 0).
    wr(5'h14, 32'h0);
    pad_in[31] = 1'b1;
    settle();
    rd(5'h0C, v);
    check("R6 R1 rising edge line 31", v, 32'h1000_0001);
    check("R9 masked irq low", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h0000_0001);
    #1 check("R9 unmasked irq high", {31'h0, irq}, 32'h1);

    // R7: writing zero does nothing, single-bit write clears one bit.
    wr(5'h0C, 32'h0);
    rd(5'h0C, v);
    check("R7 zero write no effect", v, 32'h1000_0001);
    wr(5'h0C, 32'h0000_0001);
    rd(5'h0C, v);
    check("R7 single bit cleared", v, 32'h1000_0000);
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    // R8: set it again, then clear on the very edge a new event lands.
    pad_in[31] = 1'b0;
    settle();
    rd(5'h0C, v);
    check("R6 falling edge line 31", v, 32'h1000_0001);
    wr(5'h0C, 32'h0000_0001);
    pad_in[31] = 1'b1;              // driven at a negedge
    @(posedge clk);                 // edge 1
    @(posedge clk);                 // edge 2: hit now visible
    @(negedge clk);
    bus_addr = 5'h0C; bus_wdata = 32'h0000_0001; bus_we = 1'b1;
    @(posedge clk);                 // edge 3: set and clear together
    @(negedge clk);
    bus_we = 1'b0;
    #1 check("R8 edge wins over clear", bus_rdata, 32'h1000_0001);
    check("R8 irq stays high", {31'h0, irq}, 32'h1);

    // R9: mask 0 silences irq.
    wr(5'h10, 32'h0);
    #1 check("R9 mask zero irq low", {31'h0, irq}, 32'h0);

    // R10: reserved offsets and misaligned accesses.
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v);
    check("R10 offset 0x04 reads 0", v, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v);
    check("R10 offset 0x18 reads 0", v, 32'h0);
    wr(5'h11, 32'hFFFF_FFFF);
    rd(5'h10, v);
    check("R10 misaligned write ignored", v, 32'h0);
    wr(5'h00, 32'h0000_0001);
    rd(5'h02, v);
    check("R10 misaligned read 0", v, 32'h0);
    check("R10 R3 direction at 0x00", pad_oe, 32'h8000_0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule